// File: doc/BRIEF.md
# Two-Pipe Priority Layer Compositor

This block merges up to four rectangular layers into one RGB pixel stream. It works in two steps. First, each of two pipes picks a single pixel from the enabled layers assigned to it that cover the current screen position. Inside a pipe the highest priority wins, and no blending takes place there. Second, the lower pipe (pipe 0) is alpha-blended over the background colour. The upper pipe (pipe 1) is then alpha-blended over that result.

An external raster generator supplies the screen position on `pos_x`/`pos_y` and marks each position with `pix_valid`. External fetch logic presents each layer's ARGB pixel for that position on `layer_argb`. The per-layer configuration is presented as packed static vectors, with layer i in slice i of each vector.

A quirk input imitates a known defect. When it is set, a pixel chosen for pipe 0 from a priority-0 layer that carries any transparency is thrown away and replaced by the background. The asynchronous reset is released through a two-flop synchronizer inside the block.

Top module: `dual_pipe_compositor`

## Requirements
- R1: Layer i covers (x, y) only when `layer_en[i]` is 1, X <= x < X+W and Y <= y < Y+H. X, Y, W and H are the 11-bit fields at bits [i*11 +: 11] of `layer_x`, `layer_y`, `layer_w` and `layer_h`. The left and top edges are inclusive and the right and bottom edges are exclusive.
- R2: Each pipe shows the covering layer that has the highest 2-bit priority (`layer_prio[i*2 +: 2]`, 3 highest) among the layers whose `layer_pipe[i]` bit selects that pipe (0 or 1). Lower-priority layers in the same pipe are hidden, not blended.
- R3: When two covering layers in one pipe have equal priority, the one with the lower layer index wins.
- R4: Per-pixel alpha is `layer_argb[i*32+31 -: 8]`. Red, green and blue are bits [23:16], [15:8] and [7:0] of each 32-bit word. The effective alpha is that value when `layer_galpha_en[i]` is 0. When it is 1, the effective alpha is (A*G+127)/255, with G = `layer_galpha[i*8 +: 8]`. G has no effect while its enable bit is 0.
- R5: With blend(a,t,b) = (a*t + (255-a)*b + 127)/255 per channel, the output is blend(a1, c1, blend(a0, c0, bg)). Here (a0,c0) and (a1,c1) are the effective alpha and colour of pipe 0 and pipe 1. An alpha of 255 therefore shows the top colour exactly, and an alpha of 0 shows the bottom colour exactly.
- R6: A pipe with no covering layer contributes the background colour `bg_rgb` with alpha 0. A position covered by no layer outputs `bg_rgb` unchanged.
- R7: While `quirk_en` is 1, pipe 0 contributes `bg_rgb` with alpha 0 whenever its chosen layer has priority 0 and effective alpha below 255. A pipe-0 pixel from a priority-0 layer that is opaque, or from a layer with priority above 0, is not affected. While `quirk_en` is 0 the rule never applies.
- R8: The result for a position sampled with `pix_valid` high appears on `out_rgb`, with `out_valid` high, after the third rising clock edge counting the sampling edge. `out_valid` is low otherwise, and `out_rgb` holds its last value while `out_valid` is low.
- R9: While reset is asserted, `out_valid` and `out_rgb` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Current position is a real pixel |
| pos_x | input | 11 | Current column |
| pos_y | input | 11 | Current row |
| layer_en | input | 4 | Per-layer enable |
| layer_pipe | input | 4 | Per-layer pipe select (0 or 1) |
| layer_prio | input | 8 | Per-layer 2-bit priority |
| layer_x | input | 44 | Per-layer left edge |
| layer_y | input | 44 | Per-layer top edge |
| layer_w | input | 44 | Per-layer width |
| layer_h | input | 44 | Per-layer height |
| layer_galpha | input | 32 | Per-layer 8-bit global alpha |
| layer_galpha_en | input | 4 | Per-layer global alpha enable |
| layer_argb | input | 128 | Per-layer ARGB pixel at the current position |
| bg_rgb | input | 24 | Background colour |
| quirk_en | input | 1 | Enable lowest-plane alpha defect emulation |
| out_valid | output | 1 | `out_rgb` carries a new pixel |
| out_rgb | output | 24 | Composed pixel |

## Verification
The bench probes rectangle edges one pixel inside and one pixel outside. If the comparison were off by one, the background would appear on a covered edge pixel, or a layer would bleed one pixel past its edge. Overlaps of equal priority catch a picker that lets the higher index win. Overlaps of unequal priority catch a pipe that stacks layers in index order. Translucent pipe-1 pixels, with and without a global alpha, check the rounding and confirm that a disabled global alpha is ignored; a wrong product or rounding gives a colour that is off by one or more codes. The quirk cases separate a translucent priority-0 pixel (the background must show) from an opaque one and from one with priority above 0 (no change must occur), which exposes a quirk that is missing or that fires too widely.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  typedef struct packed {
    logic [23:0] rgb;
    logic [7:0]  alpha;
  } pipe_px_t;

  // rounded division of a 0..65025 sum by 255
  function automatic logic [7:0] div255_round(input logic [16:0] t);
    return 8'((t + 17'd127) / 17'd255);
  endfunction

  // one channel: a over top, (255-a) over bottom
  function automatic logic [7:0] mix8(input logic [7:0] a,
                                      input logic [7:0] top,
                                      input logic [7:0] bot);
    logic [16:0] s;
    s = 17'(a) * 17'(top) + 17'(8'hFF - a) * 17'(bot);
    return div255_round(s);
  endfunction

endpackage

// File: rtl/dpc_layer_hit.sv
module dpc_layer_hit #(
  parameter int CW = 11
) (
  input  logic          en_i,
  input  logic [CW-1:0] px_i,
  input  logic [CW-1:0] py_i,
  input  logic [CW-1:0] lx_i,
  input  logic [CW-1:0] ly_i,
  input  logic [CW-1:0] lw_i,
  input  logic [CW-1:0] lh_i,
  input  logic [7:0]    pix_alpha_i,
  input  logic [7:0]    galpha_i,
  input  logic          galpha_en_i,
  output logic          hit_o,
  output logic [7:0]    eff_alpha_o
);
  import dpc_pkg::*;

  logic [CW:0]  x_end, y_end;
  logic         in_x, in_y;
  logic [15:0]  prod;

  always_comb begin
    x_end = {1'b0, lx_i} + {1'b0, lw_i};
    y_end = {1'b0, ly_i} + {1'b0, lh_i};
    in_x  = (px_i >= lx_i) && ({1'b0, px_i} < x_end);
    in_y  = (py_i >= ly_i) && ({1'b0, py_i} < y_end);
    hit_o = en_i && in_x && in_y;
    prod  = {8'h00, pix_alpha_i} * {8'h00, galpha_i};
    eff_alpha_o = galpha_en_i ? div255_round({1'b0, prod}) : pix_alpha_i;
  end

endmodule

// File: rtl/dpc_pipe_pick.sv
module dpc_pipe_pick #(
  parameter int N  = 4,
  parameter int PW = 2,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    cand_i,
  input  logic [N*PW-1:0] prio_i,
  input  logic [N*8-1:0]  alpha_i,
  input  logic [N*24-1:0] rgb_i,
  output logic            found_o,
  output logic [IW-1:0]   sel_idx_o,
  output logic [PW-1:0]   sel_prio_o,
  output logic [7:0]      sel_alpha_o,
  output logic [23:0]     sel_rgb_o
);

  // ascending scan, strict compare: ties keep the lower index
  always_comb begin
    found_o     = 1'b0;
    sel_idx_o   = '0;
    sel_prio_o  = '0;
    sel_alpha_o = '0;
    sel_rgb_o   = '0;
    for (int i = 0; i < N; i++) begin
      if (cand_i[i] && (!found_o || (prio_i[i*PW +: PW] > sel_prio_o))) begin
        found_o     = 1'b1;
        sel_idx_o   = IW'(i);
        sel_prio_o  = prio_i[i*PW +: PW];
        sel_alpha_o = alpha_i[i*8 +: 8];
        sel_rgb_o   = rgb_i[i*24 +: 24];
      end
    end
  end

endmodule

// File: rtl/dpc_mix3.sv
module dpc_mix3 (
  input  logic [7:0]  alpha_i,
  input  logic [23:0] top_i,
  input  logic [23:0] bot_i,
  output logic [23:0] mix_o
);
  import dpc_pkg::*;

  for (genvar c = 0; c < 3; c++) begin : g_chan
    assign mix_o[c*8 +: 8] = mix8(alpha_i, top_i[c*8 +: 8], bot_i[c*8 +: 8]);
  end

endmodule

// File: rtl/dual_pipe_compositor.sv
module dual_pipe_compositor #(
  parameter int N_LAYERS = 4,
  parameter int CW       = 11,
  parameter int PW       = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pix_valid,
  input  logic [CW-1:0]          pos_x,
  input  logic [CW-1:0]          pos_y,
  input  logic [N_LAYERS-1:0]    layer_en,
  input  logic [N_LAYERS-1:0]    layer_pipe,
  input  logic [N_LAYERS*PW-1:0] layer_prio,
  input  logic [N_LAYERS*CW-1:0] layer_x,
  input  logic [N_LAYERS*CW-1:0] layer_y,
  input  logic [N_LAYERS*CW-1:0] layer_w,
  input  logic [N_LAYERS*CW-1:0] layer_h,
  input  logic [N_LAYERS*8-1:0]  layer_galpha,
  input  logic [N_LAYERS-1:0]    layer_galpha_en,
  input  logic [N_LAYERS*32-1:0] layer_argb,
  input  logic [23:0]            bg_rgb,
  input  logic                   quirk_en,
  output logic                   out_valid,
  output logic [23:0]            out_rgb
);
  import dpc_pkg::*;

  localparam int IW     = (N_LAYERS > 1) ? $clog2(N_LAYERS) : 1;
  localparam int NPIPES = 2;

  // ---------------- reset release synchronizer ----------------
  logic [1:0] rst_sync_q;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ok = rst_sync_q[1];

  // ---------------- per-layer coverage and alpha ----------------
  logic [N_LAYERS-1:0]    hit;
  logic [N_LAYERS*8-1:0]  eff_alpha;
  logic [N_LAYERS*24-1:0] layer_rgb;

  for (genvar i = 0; i < N_LAYERS; i++) begin : g_layer
    dpc_layer_hit #(.CW(CW)) u_hit (
      .en_i        (layer_en[i]),
      .px_i        (pos_x),
      .py_i        (pos_y),
      .lx_i        (layer_x[i*CW +: CW]),
      .ly_i        (layer_y[i*CW +: CW]),
      .lw_i        (layer_w[i*CW +: CW]),
      .lh_i        (layer_h[i*CW +: CW]),
      .pix_alpha_i (layer_argb[i*32+24 +: 8]),
      .galpha_i    (layer_galpha[i*8 +: 8]),
      .galpha_en_i (layer_galpha_en[i]),
      .hit_o       (hit[i]),
      .eff_alpha_o (eff_alpha[i*8 +: 8])
    );
    assign layer_rgb[i*24 +: 24] = layer_argb[i*32 +: 24];
  end

  // ---------------- per-pipe priority selection ----------------
  logic [NPIPES-1:0][N_LAYERS-1:0] cand;
  logic [NPIPES-1:0]               found;
  logic [NPIPES-1:0][IW-1:0]       sel_idx;
  logic [NPIPES-1:0][PW-1:0]       sel_prio;
  logic [NPIPES-1:0][7:0]          sel_alpha;
  logic [NPIPES-1:0][23:0]         sel_rgb;

  for (genvar p = 0; p < NPIPES; p++) begin : g_pipe
    assign cand[p] = hit & (p == 0 ? ~layer_pipe : layer_pipe);

    dpc_pipe_pick #(.N(N_LAYERS), .PW(PW)) u_pick (
      .cand_i      (cand[p]),
      .prio_i      (layer_prio),
      .alpha_i     (eff_alpha),
      .rgb_i       (layer_rgb),
      .found_o     (found[p]),
      .sel_idx_o   (sel_idx[p]),
      .sel_prio_o  (sel_prio[p]),
      .sel_alpha_o (sel_alpha[p]),
      .sel_rgb_o   (sel_rgb[p])
    );

    for (genvar j = 0; j < N_LAYERS; j++) begin : g_chk
      // R2: no covering layer in this pipe outranks the chosen one
      p_pick_max_r2: assert property (@(posedge clk) disable iff (!rst_ok)
        (found[p] && cand[p][j]) |-> (layer_prio[j*PW +: PW] <= sel_prio[p]));
      // R3: on a priority tie the chosen index is the lowest
      p_tie_low_r3: assert property (@(posedge clk) disable iff (!rst_ok)
        (found[p] && cand[p][j] && (layer_prio[j*PW +: PW] == sel_prio[p]))
        |-> (sel_idx[p] <= IW'(j)));
    end
  end

  // ---------------- stage 1: pipe pixels, quirk ----------------
  pipe_px_t p0_d, p1_d, p0_q, p1_q;
  logic [23:0] bg_q;
  logic        v1_q, v2_q, v3_q;
  logic        quirk_hit;

  always_comb begin
    quirk_hit = quirk_en && found[0] && (sel_prio[0] == '0) && (sel_alpha[0] != 8'hFF);
    if (found[0] && !quirk_hit) begin
      p0_d.rgb   = sel_rgb[0];
      p0_d.alpha = sel_alpha[0];
    end else begin
      p0_d.rgb   = bg_rgb;
      p0_d.alpha = 8'h00;
    end
    if (found[1]) begin
      p1_d.rgb   = sel_rgb[1];
      p1_d.alpha = sel_alpha[1];
    end else begin
      p1_d.rgb   = bg_rgb;
      p1_d.alpha = 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      p0_q <= '0;
      p1_q <= '0;
      bg_q <= '0;
    end else if (pix_valid) begin
      p0_q <= p0_d;
      p1_q <= p1_d;
      bg_q <= bg_rgb;
    end
  end

  // ---------------- stage 2: pipe 0 over background ----------------
  logic [23:0] lower_d, lower_q;
  pipe_px_t    p1_q2;

  dpc_mix3 u_mix_low (
    .alpha_i (p0_q.alpha),
    .top_i   (p0_q.rgb),
    .bot_i   (bg_q),
    .mix_o   (lower_d)
  );

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      lower_q <= '0;
      p1_q2   <= '0;
    end else if (v1_q) begin
      lower_q <= lower_d;
      p1_q2   <= p1_q;
    end
  end

  // ---------------- stage 3: pipe 1 over the lower result ----------------
  logic [23:0] final_d;

  dpc_mix3 u_mix_top (
    .alpha_i (p1_q2.alpha),
    .top_i   (p1_q2.rgb),
    .bot_i   (lower_q),
    .mix_o   (final_d)
  );

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok)   out_rgb <= '0;
    else if (v2_q) out_rgb <= final_d;
  end

  // ---------------- valid pipeline ----------------
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
      v3_q <= 1'b0;
    end else begin
      v1_q <= pix_valid;
      v2_q <= v1_q;
      v3_q <= v2_q;
    end
  end
  assign out_valid = v3_q;

  // ---------------- assertions ----------------
  // R8: a valid output always traces back to a sampled pixel three edges earlier
  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    out_valid |-> $past(pix_valid, 3));

  // R7: translucent priority-0 pipe-0 pixel is replaced by background
  p_quirk_bg_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    (pix_valid && quirk_en && found[0] && (sel_prio[0] == '0) && (sel_alpha[0] != 8'hFF))
    |=> ((p0_q.alpha == 8'h00) && (p0_q.rgb == $past(bg_rgb))));

  // R6: an empty pipe contributes zero alpha
  p_empty_pipe_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    (pix_valid && !found[1]) |=> (p1_q.alpha == 8'h00));

  // R5: opaque upper pipe shows its colour exactly
  p_opaque_top_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    (v2_q && (p1_q2.alpha == 8'hFF)) |=> (out_rgb == $past(p1_q2.rgb)));

  // R5: transparent upper pipe passes the lower result through
  p_clear_top_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    (v2_q && (p1_q2.alpha == 8'h00)) |=> (out_rgb == $past(lower_q)));

  // R8: output colour holds while no new pixel arrives
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    !v2_q |=> $stable(out_rgb));

endmodule

// File: tb/dual_pipe_compositor_test.sv
`timescale 1ns/1ps
module dual_pipe_compositor_test;

  localparam int N  = 4;
  localparam int CW = 11;
  localparam int PW = 2;
  localparam int NV = 13;
  localparam logic [23:0] BG = 24'h123456;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            pix_valid;
  logic [CW-1:0]   pos_x, pos_y;
  logic [N-1:0]    layer_en, layer_pipe, layer_galpha_en;
  logic [N*PW-1:0] layer_prio;
  logic [N*CW-1:0] layer_x, layer_y, layer_w, layer_h;
  logic [N*8-1:0]  layer_galpha;
  logic [N*32-1:0] layer_argb;
  logic [23:0]     bg_rgb;
  logic            quirk_en;
  logic            out_valid;
  logic [23:0]     out_rgb;

  int nvec = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dual_pipe_compositor #(.N_LAYERS(N), .CW(CW), .PW(PW)) uut (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid),
    .pos_x(pos_x), .pos_y(pos_y),
    .layer_en(layer_en), .layer_pipe(layer_pipe), .layer_prio(layer_prio),
    .layer_x(layer_x), .layer_y(layer_y), .layer_w(layer_w), .layer_h(layer_h),
    .layer_galpha(layer_galpha), .layer_galpha_en(layer_galpha_en),
    .layer_argb(layer_argb), .bg_rgb(bg_rgb), .quirk_en(quirk_en),
    .out_valid(out_valid), .out_rgb(out_rgb)
  );

  // x, y, expected colour with the base layer setup
  localparam logic [45:0] VEC [NV] = '{
    {11'd0,   11'd0,  24'h123456},  // R6 nothing covers
    {11'd10,  11'd10, 24'h110000},  // R1 top-left corner inclusive
    {11'd29,  11'd29, 24'h002200},  // R3 tie L1/L2, lower index
    {11'd30,  11'd15, 24'h123456},  // R1 right edge exclusive
    {11'd15,  11'd25, 24'h110000},  // R1 only layer 0
    {11'd22,  11'd22, 24'h002200},  // R2 higher priority hides lower
    {11'd39,  11'd39, 24'h002200},  // R1 last covered pixel
    {11'd40,  11'd40, 24'h123456},  // R1 past bottom-right
    {11'd100, 11'd0,  24'h444444},  // R5 opaque pipe 1
    {11'd109, 11'd4,  24'h444444},  // R1 pipe 1 corner
    {11'd110, 11'd4,  24'h123456},  // R1 pipe 1 right edge
    {11'd109, 11'd5,  24'h123456},  // R1 pipe 1 bottom edge
    {11'd25,  11'd10, 24'h110000}   // R2 layer 0 alone
  };

  function automatic logic [7:0] ref_mix(input int a, input int t, input int b);
    return 8'((a * t + (255 - a) * b + 127) / 255);
  endfunction

  function automatic logic [23:0] ref_mix24(input int a, input logic [23:0] t,
                                            input logic [23:0] b);
    return {ref_mix(a, int'(t[23:16]), int'(b[23:16])),
            ref_mix(a, int'(t[15:8]),  int'(b[15:8])),
            ref_mix(a, int'(t[7:0]),   int'(b[7:0]))};
  endfunction

  task automatic set_layer(input int i, input logic en, input logic pipe,
                           input logic [1:0] prio, input int x, input int y,
                           input int w, input int h, input logic [31:0] argb,
                           input logic [7:0] ga, input logic ga_en);
    layer_en[i]           = en;
    layer_pipe[i]         = pipe;
    layer_prio[i*PW +: PW] = prio;
    layer_x[i*CW +: CW]   = CW'(x);
    layer_y[i*CW +: CW]   = CW'(y);
    layer_w[i*CW +: CW]   = CW'(w);
    layer_h[i*CW +: CW]   = CW'(h);
    layer_argb[i*32 +: 32] = argb;
    layer_galpha[i*8 +: 8] = ga;
    layer_galpha_en[i]    = ga_en;
  endtask

  task automatic base_setup();
    set_layer(0, 1'b1, 1'b0, 2'd1, 10, 10, 20, 20, 32'hFF110000, 8'h00, 1'b0);
    set_layer(1, 1'b1, 1'b0, 2'd2, 20, 20, 20, 20, 32'hFF002200, 8'h00, 1'b0);
    set_layer(2, 1'b1, 1'b0, 2'd2, 25, 25, 10, 10, 32'hFF000033, 8'h00, 1'b0);
    set_layer(3, 1'b1, 1'b1, 2'd0, 100, 0, 10, 5, 32'hFF444444, 8'h00, 1'b0);
    quirk_en = 1'b0;
  endtask

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one pixel, return after the third edge at a falling edge
  task automatic apply(input int x, input int y);
    @(negedge clk);
    pos_x = CW'(x); pos_y = CW'(y); pix_valid = 1'b1;
    @(negedge clk);
    pix_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic px_check(input string req, input int x, input int y,
                          input logic [23:0] exp);
    apply(x, y);
    check({req, " valid"}, {23'd0, out_valid}, 24'd1);
    check(req, out_rgb, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    nvec++;
    nfail++;
    $display("FAIL watchdog actual hung expected finish");
    finish_run();
  end

  initial begin
    logic [23:0] held;
    int eff;
    rst_n = 1'b0; pix_valid = 1'b0; pos_x = '0; pos_y = '0;
    layer_en = '0; layer_pipe = '0; layer_prio = '0; layer_galpha_en = '0;
    layer_x = '0; layer_y = '0; layer_w = '0; layer_h = '0;
    layer_galpha = '0; layer_argb = '0; bg_rgb = BG; quirk_en = 1'b0;
    base_setup();
    repeat (4) @(negedge clk);
    // R9 reset state
    check("R9 out_valid in reset", {23'd0, out_valid}, 24'd0);
    check("R9 out_rgb in reset", out_rgb, 24'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      px_check($sformatf("R1/R2/R3/R6 vector %0d", v),
               int'(VEC[v][45:35]), int'(VEC[v][34:24]), VEC[v][23:0]);
    end

    // R8 latency: not valid after two edges, valid after three
    @(negedge clk);
    pos_x = 11'd12; pos_y = 11'd12; pix_valid = 1'b1;
    @(negedge clk);
    pix_valid = 1'b0;
    @(negedge clk);
    check("R8 not valid after two edges", {23'd0, out_valid}, 24'd0);
    @(negedge clk);
    check("R8 valid after three edges", {23'd0, out_valid}, 24'd1);
    held = out_rgb;
    repeat (3) @(negedge clk);
    check("R8 valid drops", {23'd0, out_valid}, 24'd0);
    check("R8 output holds", out_rgb, held);

    // R5 translucent pipe 1 over opaque pipe 0
    set_layer(3, 1'b1, 1'b1, 2'd0, 10, 10, 5, 5, 32'h80FFFFFF, 8'h80, 1'b0);
    px_check("R5 half alpha blend", 12, 12, ref_mix24(128, 24'hFFFFFF, 24'h110000));
    // R4 global alpha disabled has no effect (same result as above)
    px_check("R4 galpha ignored when off", 14, 14, ref_mix24(128, 24'hFFFFFF, 24'h110000));
    // R4 product of per-pixel and global alpha
    set_layer(3, 1'b1, 1'b1, 2'd0, 10, 10, 5, 5, 32'h80FFFFFF, 8'h80, 1'b1);
    eff = (128 * 128 + 127) / 255;
    px_check("R4 galpha product", 12, 12, ref_mix24(eff, 24'hFFFFFF, 24'h110000));
    // R6 translucent pipe 1 over an empty pipe 0: blends with background
    set_layer(3, 1'b1, 1'b1, 2'd0, 200, 200, 5, 5, 32'h80FFFFFF, 8'h00, 1'b0);
    px_check("R6 pipe 1 over background", 201, 201, ref_mix24(128, 24'hFFFFFF, BG));

    // R7 quirk cases, pipe 1 away from the probe point
    eff = (255 * 128 + 127) / 255;
    set_layer(0, 1'b1, 1'b0, 2'd0, 10, 10, 20, 20, 32'hFF110000, 8'h80, 1'b1);
    quirk_en = 1'b0;
    px_check("R7 quirk off keeps blend", 15, 15, ref_mix24(eff, 24'h110000, BG));
    quirk_en = 1'b1;
    px_check("R7 quirk discards pixel", 15, 15, BG);
    set_layer(0, 1'b1, 1'b0, 2'd1, 10, 10, 20, 20, 32'hFF110000, 8'h80, 1'b1);
    px_check("R7 quirk spares priority 1", 15, 15, ref_mix24(eff, 24'h110000, BG));
    set_layer(0, 1'b1, 1'b0, 2'd0, 10, 10, 20, 20, 32'hFF110000, 8'h80, 1'b0);
    px_check("R7 quirk spares opaque", 15, 15, 24'h110000);
    quirk_en = 1'b0;

    // R1 disabled layer does not cover
    set_layer(0, 1'b0, 1'b0, 2'd1, 10, 10, 20, 20, 32'hFF110000, 8'h00, 1'b0);
    px_check("R1 disabled layer", 15, 15, BG);

    finish_run();
  end

endmodule